// File: doc/BRIEF.md
# Trace Capture RAM Buffer

This block stores a stream of trace bytes in a dedicated on-chip RAM and lets a debug-side reader drain them one byte at a time. Trace bytes arrive over a valid/ready handshake. A write pointer, a read pointer and a fill count track the buffered bytes. When the buffer is full, one of two policies applies. In wrap mode the oldest byte is overwritten. In stop mode new bytes are accepted on the handshake and then thrown away.

A programmable byte threshold drives a level-sensitive nearly-full interrupt, which software can acknowledge with a write-one-to-clear pulse. A halt-request output can ask the core to stop while the buffer is full. A pointer-reset command empties the buffer and clears every flag.

A four-state machine tracks the capture condition:
- `ST_OFF`: capture is disabled.
- `ST_FILL`: capture is enabled and there is room.
- `ST_FULL_WRAP`: the buffer is full under the wrap policy.
- `ST_FULL_STOP`: the buffer is full under the stop policy.

Each clock edge moves the machine to a new state:
- From any state to `ST_OFF` when enable is low.
- To `ST_FILL` when enable is high and the next fill count is below the depth.
- To `ST_FULL_WRAP` or `ST_FULL_STOP`, chosen by the policy input, when the next fill count equals the depth.

The halt request is raised only in the two full states.

Top module: `trace_ram_sink`

## Requirements
- R1: After reset, the fill level is 0. The wrapped, overflow, interrupt, halt, rd_valid and rd_empty outputs are all 0, and rd_data is 0.
- R2: A byte with in_valid high, while capture is enabled and the buffer is not full, is stored and raises the fill level by one on the next edge. in_ready is high except in a cycle where the pointer reset is asserted.
- R3: A read request on a non-empty buffer gives the oldest stored byte on rd_data, with rd_valid high, in the next cycle, and lowers the fill level by one. Bytes come out in the order they were written.
- R4: A read request on an empty buffer gives rd_valid high, rd_empty high and rd_data equal to 0 in the next cycle. rd_data is 0 in every cycle without a returned byte.
- R5: With the stop policy low and the buffer full, an incoming byte overwrites the oldest byte. The fill level stays at the depth, and the sticky wrapped flag is set.
- R6: With the stop policy high and the buffer full, an incoming byte is acknowledged and dropped. The stored contents do not change, and the sticky overflow flag is set.
- R7: A read and a write in the same cycle on a full buffer are handled read first. The oldest byte is returned, the new byte is stored without overwrite or drop, and the fill level stays at the depth.
- R8: While capture is disabled, incoming bytes are ignored and the fill level does not change.
- R9: The interrupt is high exactly when the threshold is non-zero, the fill level is at least the threshold, and no acknowledge is pending.
- R10: An acknowledge pulse, taken while the next fill level is at or above the threshold, holds the interrupt low. The hold lasts until the fill level drops below the threshold.
- R11: The halt request is high exactly when halt is enabled, capture was enabled at the last edge, and the buffer is full.
- R12: A pointer reset empties the buffer and clears the wrapped flag, the overflow flag and any pending acknowledge. A read or write in the same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Capture enable |
| cfg_stop_on_full | input | 1 | 1: drop when full, 0: overwrite oldest |
| cfg_halt_en | input | 1 | Allow the halt request |
| cfg_thresh | input | 7 | Nearly-full byte threshold; 0 disables the interrupt |
| cmd_ptr_reset | input | 1 | Pulse: clear the pointers and flags |
| cmd_irq_clr | input | 1 | Pulse: write-one-to-clear acknowledge of the interrupt |
| in_valid | input | 1 | Trace byte valid |
| in_data | input | 8 | Trace byte |
| in_ready | output | 1 | Trace byte accepted |
| rd_req | input | 1 | Debug-side read request |
| rd_data | output | 8 | Returned byte, 0 when none is returned |
| rd_valid | output | 1 | Response to last cycle's request |
| rd_empty | output | 1 | Last request found the buffer empty |
| fill_level | output | 7 | Bytes held |
| wrapped | output | 1 | Sticky: an old byte was overwritten |
| overflow | output | 1 | Sticky: a byte was dropped |
| irq_nearly_full | output | 1 | Nearly-full interrupt (level) |
| halt_req | output | 1 | Core halt request |

## Verification
The assertions assume two things about the inputs: they are known from the first edge after reset, and cfg_thresh never exceeds the buffer depth. Given that, a fill count above the depth, or a halt request below full, can only come from a logic fault. The stimulus draws the threshold only from 0 to the depth. It changes the policy and enable settings at block boundaries between random stretches, and it holds them stable through each edge and the sampling point that follows. Directed phases drive the buffer into full-and-wrap, full-and-drop, simultaneous read and write at full, and acknowledge-while-above-threshold. A purely random mix reaches these cases only rarely.

// File: rtl/trace_sink_pkg.sv
package trace_sink_pkg;
    typedef enum logic [1:0] {
        ST_OFF       = 2'd0,
        ST_FILL      = 2'd1,
        ST_FULL_WRAP = 2'd2,
        ST_FULL_STOP = 2'd3
    } sink_state_e;
endpackage

// File: rtl/trace_sink_mem.sv
module trace_sink_mem #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) store[wr_addr] <= wr_data;
    end

    // Registered read sees the pre-write contents: read-first on a shared slot.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= store[rd_addr];
        else            rd_data <= '0;
    end
endmodule

// File: rtl/trace_sink_ptrs.sv
module trace_sink_ptrs #(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          preset,
    input  logic          wr_fire,
    input  logic          rd_req,
    input  logic          stop_on_full,
    output logic          do_read,
    output logic          wr_store,
    output logic [AW-1:0] wptr,
    output logic [AW-1:0] rptr,
    output logic [CW-1:0] count,
    output logic [CW-1:0] count_next,
    output logic          wrapped,
    output logic          overflow
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic full, room, grow, overwrite, drop;

    always_comb begin
        full      = (count == FULL_CNT);
        do_read   = rd_req && (count != '0) && !preset;
        room      = !full || do_read;
        wr_store  = wr_fire && !preset && (room || !stop_on_full);
        overwrite = wr_store && !room;
        drop      = wr_fire && !preset && !room && stop_on_full;
        grow      = wr_store && !overwrite;
        if (preset) count_next = '0;
        else        count_next = count + CW'(grow) - CW'(do_read);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr     <= '0;
            rptr     <= '0;
            count    <= '0;
            wrapped  <= 1'b0;
            overflow <= 1'b0;
        end else if (preset) begin
            wptr     <= '0;
            rptr     <= '0;
            count    <= '0;
            wrapped  <= 1'b0;
            overflow <= 1'b0;
        end else begin
            count <= count_next;
            if (wr_store)             wptr <= wptr + 1'b1;
            if (do_read || overwrite) rptr <= rptr + 1'b1;
            if (overwrite)            wrapped  <= 1'b1;
            if (drop)                 overflow <= 1'b1;
        end
    end

    assert_fill_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);
    assert_wrap_keeps_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_fire && !stop_on_full && !rd_req && !preset) |=> (full && wrapped));
    assert_stop_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_fire && stop_on_full && !rd_req && !preset) |=> (overflow && $stable(wptr) && full));
    assert_ptr_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
        preset |=> (count == '0 && !wrapped && !overflow && wptr == '0));
endmodule

// File: rtl/trace_sink_irq.sv
module trace_sink_irq #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          preset,
    input  logic          ack_pulse,
    input  logic [CW-1:0] thresh,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] count_next,
    output logic          irq
);
    logic ack;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  ack <= 1'b0;
        else if (preset)             ack <= 1'b0;
        else if (count_next < thresh) ack <= 1'b0;
        else if (ack_pulse)          ack <= 1'b1;
    end

    always_comb irq = (thresh != '0) && (count >= thresh) && !ack;

    assert_ack_from_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> $past(ack_pulse));
    assert_irq_needs_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (count >= thresh));
endmodule

// File: rtl/trace_ram_sink.sv
module trace_ram_sink #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_stop_on_full,
    input  logic              cfg_halt_en,
    input  logic [CW-1:0]     cfg_thresh,
    input  logic              cmd_ptr_reset,
    input  logic              cmd_irq_clr,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    input  logic              rd_req,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_empty,
    output logic [CW-1:0]     fill_level,
    output logic              wrapped,
    output logic              overflow,
    output logic              irq_nearly_full,
    output logic              halt_req
);
    import trace_sink_pkg::*;

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    sink_state_e   state, state_next;
    logic          wr_fire, do_read, wr_store;
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] count, count_next;

    assign in_ready   = !cmd_ptr_reset;
    assign wr_fire    = in_valid && cfg_enable && !cmd_ptr_reset;
    assign fill_level = count;

    trace_sink_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk(clk), .rst_n(rst_n), .preset(cmd_ptr_reset), .wr_fire(wr_fire),
        .rd_req(rd_req), .stop_on_full(cfg_stop_on_full), .do_read(do_read),
        .wr_store(wr_store), .wptr(wptr), .rptr(rptr), .count(count),
        .count_next(count_next), .wrapped(wrapped), .overflow(overflow)
    );

    trace_sink_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_store), .wr_addr(wptr),
        .wr_data(in_data), .rd_en(do_read), .rd_addr(rptr), .rd_data(rd_data)
    );

    trace_sink_irq #(.CW(CW)) u_irq (
        .clk(clk), .rst_n(rst_n), .preset(cmd_ptr_reset), .ack_pulse(cmd_irq_clr),
        .thresh(cfg_thresh), .count(count), .count_next(count_next), .irq(irq_nearly_full)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_empty <= 1'b0;
        end else begin
            rd_valid <= rd_req && !cmd_ptr_reset;
            rd_empty <= rd_req && !cmd_ptr_reset && (count == '0);
        end
    end

    // Capture state machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_next;
    end

    always_comb begin
        if (!cfg_enable)                 state_next = ST_OFF;
        else if (count_next == FULL_CNT) state_next = cfg_stop_on_full ? ST_FULL_STOP : ST_FULL_WRAP;
        else                             state_next = ST_FILL;
    end

    // Capture state machine: outputs
    always_comb begin
        unique case (state)
            ST_OFF:       halt_req = 1'b0;
            ST_FILL:      halt_req = 1'b0;
            ST_FULL_WRAP: halt_req = cfg_halt_en;
            ST_FULL_STOP: halt_req = cfg_halt_en;
            default:      halt_req = 1'b0;
        endcase
    end

    assert_halt_full_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |-> (fill_level == FULL_CNT));
    assert_empty_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_empty |-> (rd_valid && rd_data == '0));
    assert_read_drains_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !cmd_ptr_reset && count != '0 && !in_valid) |=> (fill_level == $past(count) - 1'b1));
endmodule

// File: tb/tb_trace_ram_sink.sv
module tb_trace_ram_sink;
    localparam int DEPTH = 64;
    localparam int CW    = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_enable = 0, cfg_stop_on_full = 0, cfg_halt_en = 0;
    logic [CW-1:0] cfg_thresh = '0;
    logic          cmd_ptr_reset = 0, cmd_irq_clr = 0, in_valid = 0, rd_req = 0;
    logic [7:0]    in_data = '0;
    logic          in_ready, rd_valid, rd_empty, wrapped, overflow, irq_nearly_full, halt_req;
    logic [7:0]    rd_data;
    logic [CW-1:0] fill_level;

    trace_ram_sink #(.DEPTH(DEPTH), .DATA_W(8)) dut (.*);

    always #4 clk = ~clk;

    int n_checks = 0, n_fail = 0;
    bit finished = 0;

    // reference model
    logic [7:0] mq[$];
    bit m_wrapped, m_ovf, m_ack, m_rdv, m_empty, m_en_edge;
    logic [7:0] m_rdd;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d @%0t", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_irq();
        return (cfg_thresh != 0) && (mq.size() >= int'(cfg_thresh)) && !m_ack;
    endfunction

    function automatic bit exp_halt();
        return cfg_halt_en && m_en_edge && (mq.size() == DEPTH);
    endfunction

    task automatic model_edge();
        m_en_edge = cfg_enable;
        if (cmd_ptr_reset) begin
            mq.delete(); m_wrapped = 0; m_ovf = 0; m_ack = 0;
            m_rdv = 0; m_empty = 0; m_rdd = 0;
            return;
        end
        m_rdv = rd_req; m_empty = 0; m_rdd = 0;
        if (rd_req) begin
            if (mq.size() > 0) m_rdd = mq.pop_front();
            else m_empty = 1;
        end
        if (in_valid && cfg_enable) begin
            if (mq.size() == DEPTH) begin
                if (cfg_stop_on_full) m_ovf = 1;
                else begin void'(mq.pop_front()); mq.push_back(in_data); m_wrapped = 1; end
            end else mq.push_back(in_data);
        end
        if (mq.size() < int'(cfg_thresh)) m_ack = 0;
        else if (cmd_irq_clr) m_ack = 1;
    endtask

    task automatic compare();
        chk(fill_level == CW'(mq.size()), "R2 fill", fill_level, mq.size());
        chk(in_ready == !cmd_ptr_reset, "R2 in_ready", in_ready, !cmd_ptr_reset);
        chk(rd_valid == m_rdv, "R3 rd_valid", rd_valid, m_rdv);
        chk(rd_data == m_rdd, "R3 rd_data", rd_data, m_rdd);
        chk(rd_empty == m_empty, "R4 rd_empty", rd_empty, m_empty);
        chk(wrapped == m_wrapped, "R5 wrapped", wrapped, m_wrapped);
        chk(overflow == m_ovf, "R6 overflow", overflow, m_ovf);
        chk(irq_nearly_full == exp_irq(), "R9 irq", irq_nearly_full, exp_irq());
        chk(halt_req == exp_halt(), "R11 halt", halt_req, exp_halt());
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        #2;
        compare();
        @(negedge clk);
    endtask

    task automatic cyc(input bit v, input logic [7:0] d, input bit r);
        in_valid = v; in_data = d; rd_req = r;
        step();
        in_valid = 0; rd_req = 0; cmd_ptr_reset = 0; cmd_irq_clr = 0;
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int fill_before;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(fill_level == 0 && !wrapped && !overflow && !irq_nearly_full && !halt_req
            && !rd_valid && !rd_empty && rd_data == 0, "R1 reset state", fill_level, 0);
        rst_n = 1;
        @(negedge clk);
        m_en_edge = 0; m_rdd = 0;

        cfg_enable = 1;
        // R4 read of empty buffer
        cyc(0, 0, 1);
        chk(rd_valid && rd_empty && rd_data == 0, "R4 empty read", rd_data, 0);
        // R2/R3 order
        cyc(1, 8'h11, 0); cyc(1, 8'h22, 0); cyc(1, 8'h33, 0);
        cyc(0, 0, 1);
        chk(rd_data == 8'h11, "R3 oldest first", rd_data, 8'h11);
        cyc(0, 0, 1); cyc(0, 0, 1);
        chk(rd_data == 8'h33 && fill_level == 0, "R3 last byte", rd_data, 8'h33);

        // R5 wrap and R11 halt
        cfg_halt_en = 1;
        for (int i = 0; i < DEPTH + 3; i++) cyc(1, 8'(i + 1), 0);
        chk(wrapped && fill_level == DEPTH, "R5 wrap set", wrapped, 1);
        chk(halt_req, "R11 halt at full", halt_req, 1);
        cyc(0, 0, 1);
        chk(rd_data == 8'd4, "R5 oldest overwritten", rd_data, 4);
        cyc(1, 8'hA0, 0);
        // R7 simultaneous read and write when full
        cyc(1, 8'hA1, 1);
        chk(rd_data == 8'd5 && fill_level == DEPTH, "R7 read-first at full", rd_data, 5);

        // R12 pointer reset, concurrent read ignored
        cmd_ptr_reset = 1;
        cyc(1, 8'h55, 1);
        chk(fill_level == 0 && !wrapped && !rd_valid && !halt_req, "R12 pointer reset", fill_level, 0);

        // R6 stop policy
        cfg_stop_on_full = 1;
        for (int i = 0; i < DEPTH; i++) cyc(1, 8'(8'h80 + i), 0);
        cyc(1, 8'hEE, 0); cyc(1, 8'hEF, 0);
        chk(overflow && !wrapped && fill_level == DEPTH, "R6 dropped", overflow, 1);
        cyc(0, 0, 1);
        chk(rd_data == 8'h80, "R6 contents kept", rd_data, 8'h80);

        // R8 disabled capture
        cfg_enable = 0;
        fill_before = fill_level;
        for (int i = 0; i < 5; i++) cyc(1, 8'h77, 0);
        chk(fill_level == CW'(fill_before) && !halt_req, "R8 disabled ignores", fill_level, fill_before);
        cfg_enable = 1; cfg_halt_en = 0;
        cmd_ptr_reset = 1; cyc(0, 0, 0);

        // R9 / R10 interrupt
        cfg_thresh = 7'd10; cfg_stop_on_full = 0;
        for (int i = 0; i < 9; i++) cyc(1, 8'(i), 0);
        chk(!irq_nearly_full, "R9 below threshold", irq_nearly_full, 0);
        cyc(1, 8'h09, 0);
        chk(irq_nearly_full, "R9 at threshold", irq_nearly_full, 1);
        cmd_irq_clr = 1; cyc(0, 0, 0);
        chk(!irq_nearly_full, "R10 acknowledged", irq_nearly_full, 0);
        cyc(1, 8'h0A, 0);
        chk(!irq_nearly_full, "R10 stays acked above", irq_nearly_full, 0);
        cyc(0, 0, 1); cyc(0, 0, 1);
        chk(!irq_nearly_full && fill_level == 9, "R9 below after reads", irq_nearly_full, 0);
        cyc(1, 8'h0B, 0);
        chk(irq_nearly_full, "R10 re-armed", irq_nearly_full, 1);

        // constrained random
        void'($urandom(32'h5EED_1234));
        for (int blk = 0; blk < 15; blk++) begin
            cfg_enable       = ($urandom_range(0, 9) != 0);
            cfg_stop_on_full = $urandom_range(0, 1);
            cfg_halt_en      = $urandom_range(0, 1);
            cfg_thresh       = CW'($urandom_range(0, DEPTH));
            for (int i = 0; i < 200; i++) begin
                int wr_bias = (blk % 3 == 0) ? 8 : 5;
                cmd_ptr_reset = ($urandom_range(0, 199) == 0);
                cmd_irq_clr   = ($urandom_range(0, 15) == 0);
                cyc($urandom_range(0, 9) < wr_bias, 8'($urandom), $urandom_range(0, 9) < 4);
            end
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule